// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider with Monitor Tap

This block sits between a voltage-controlled oscillator and a phase comparator. On the oscillator side, a 32/33 dual-modulus prescaler feeds a main counter and a swallow counter, so the programmable chain divides by 32 times the main factor plus the swallow count. On the reference side, a small counter divides the reference clock by a ratio chosen from a short list. Each chain marks the end of every period with a single-cycle pulse, and the phase comparator consumes those pulses.

A monitor pin can carry one of several signals: the externally computed lock flag, either divider output halved, the reference output divided by 512, or the raw reference pulse. The top bit of the monitor code also drives a request to put the charge pump into high impedance. Division codes are captured only at the end of a period, so that software can rewrite them at any time without producing a short or a long period.

Top module: `pll_div_core`

## Requirements
- R1: Over one period of the oscillator chain, the prescaler divides by 33 for the first SSC prescaler cycles and by 32 for the rest. The period length is therefore 32×SMC+SSC oscillator cycles.
- R2: The 2-bit main code sets SMC as 32 plus the code value: 00→32, 01→33, 10→34, 11→35.
- R3: The 5-bit swallow code sets SSC to its binary value, 0 to 31. Both ends of this range give exact period lengths.
- R4: The 2-bit reference code sets the reference division: 00→3, 01→4, 10→6, 11→8 reference cycles per period.
- R5: `pc_pulse` and `ref_pulse` are high for exactly one cycle of their own clock. That cycle is the last cycle of each period.
- R6: Division codes are sampled only on the clock edge that ends a period. A code change made in the middle of a period leaves that period's length unchanged and applies to the next period.
- R7: While `rst_n` is low, both pulses are low and the captured codes are main 00, swallow 0 and reference 00. After release, the first `pc_pulse` therefore falls in oscillator cycle 1024 and the first `ref_pulse` in reference cycle 3, whatever the code inputs hold.
- R8: Monitor codes 000 and 100 put `lock_in` on `mon_out`.
- R9: Monitor codes 001 and 101 put on `mon_out` a flop that toggles after each `ref_pulse`, reset to 0. This gives a half period of one reference division.
- R10: Monitor codes 010 and 110 put on `mon_out` a flop that toggles after each `pc_pulse`, reset to 0. This gives a half period of one oscillator-chain division.
- R11: Monitor code 011 puts on `mon_out` the reference output divided by 512, which toggles every 256 reference pulses. Code 111 puts `ref_pulse` itself on `mon_out`.
- R12: `cp_hiz` equals bit 2 of `test_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Oscillator clock being divided |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both chains |
| main_code | input | 2 | Main factor select |
| swallow_code | input | 5 | Number of divide-by-33 prescaler cycles |
| ref_code | input | 2 | Reference ratio select |
| test_code | input | 3 | Monitor source select |
| lock_in | input | 1 | Lock flag from the external detector |
| pc_pulse | output | 1 | End-of-period pulse of the oscillator chain |
| ref_pulse | output | 1 | End-of-period pulse of the reference chain |
| mon_out | output | 1 | Monitor output |
| cp_hiz | output | 1 | Charge-pump high-impedance request |

## Verification
The assertions assume that every main factor is at least 3 prescaler cycles and every reference ratio at least 2 cycles, so that two pulses can never come back to back. They also assume that the swallow count never exceeds the main factor. With the default widths this holds for every code. The bench changes codes only on the falling edge, either just after a detected pulse or well inside a period. Code changes therefore never land near the sampling edge, and each measured period has one known expected length.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

  localparam int REF_RATIO_MAX = 8;

  typedef enum logic [1:0] {
    SRC_LOCK     = 2'd0,
    SRC_REF_HALF = 2'd1,
    SRC_PC_HALF  = 2'd2,
    SRC_REF_SLOW = 2'd3
  } mon_src_e;

  function automatic int main_ratio(input int code, input int base);
    return base + code;
  endfunction

  function automatic int chain_ratio(input int smc, input int ssc, input int base);
    return base * smc + ssc;
  endfunction

  function automatic int ref_ratio(input int code);
    case (code)
      0:       return 3;
      1:       return 4;
      2:       return 6;
      default: return REF_RATIO_MAX;
    endcase
  endfunction

endpackage

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
  parameter int BASE = 32,
  localparam int W = $clog2(BASE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_hi,
  output logic tc
);
  logic [W-1:0] cnt;
  logic [W-1:0] top;

  assign top = mod_hi ? W'(BASE) : W'(BASE - 1);
  assign tc  = (cnt == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (tc) cnt <= '0;
    else         cnt <= cnt + 1'b1;
  end

  // R1: counter never runs past the long modulus
  p_pre_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= W'(BASE));

  // R1: the modulus request from the swallow logic is held within a prescaler cycle
  p_mod_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(mod_hi));

endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl #(
  parameter int BASE   = 32,
  parameter int MAIN_W = 2,
  parameter int SWAL_W = 5,
  localparam int CW = $clog2(BASE + (1 << MAIN_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_tc,
  input  logic [MAIN_W-1:0] main_code,
  input  logic [SWAL_W-1:0] swallow_code,
  output logic              mod_hi,
  output logic              pc_tc
);
  logic [MAIN_W-1:0] main_l;
  logic [SWAL_W-1:0] swal_l;
  logic [CW-1:0]     mcount;
  logic [CW-1:0]     smc;
  logic              last;

  assign smc    = CW'(pll_div_pkg::main_ratio(int'(main_l), BASE));
  assign last   = (mcount == smc - 1'b1);
  assign pc_tc  = pre_tc && last;
  assign mod_hi = (mcount < CW'(swal_l));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcount <= '0;
      main_l <= '0;
      swal_l <= '0;
    end else if (pc_tc) begin
      mcount <= '0;
      main_l <= main_code;
      swal_l <= swallow_code;
    end else if (pre_tc) begin
      mcount <= mcount + 1'b1;
    end
  end

  // R5: end-of-period pulse lasts one cycle
  p_pc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_tc |=> !pc_tc);

  // R6: captured codes move only at the end of a period
  p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_tc |=> ($stable(main_l) && $stable(swal_l)));

  // R1: the long modulus ends only on a prescaler terminal count
  p_mod_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_hi) |-> $past(pre_tc));

endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int REF_W = 2,
  localparam int CW = $clog2(pll_div_pkg::REF_RATIO_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] ref_code,
  output logic             tc
);
  logic [REF_W-1:0] code_l;
  logic [CW-1:0]    rcnt;
  logic [CW-1:0]    last_cnt;

  assign last_cnt = CW'(pll_div_pkg::ref_ratio(int'(code_l)) - 1);
  assign tc       = (rcnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt   <= '0;
      code_l <= '0;
    end else if (tc) begin
      rcnt   <= '0;
      code_l <= ref_code;
    end else begin
      rcnt <= rcnt + 1'b1;
    end
  end

  // R5: reference pulse lasts one cycle
  p_ref_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);

  // R4: count stays inside the selected ratio
  p_ref_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= last_cnt);

endmodule

// File: rtl/mon_tap.sv
module mon_tap #(
  parameter int SLOW_DIV = 512,
  localparam int SLOW_HALF = SLOW_DIV / 2,
  localparam int SW = $clog2(SLOW_HALF)
) (
  input  logic       vco_clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       pc_tc,
  input  logic       ref_tc,
  input  logic       lock_in,
  input  logic [2:0] test_code,
  output logic       mon_out,
  output logic       cp_hiz
);
  import pll_div_pkg::*;

  logic          pc_half;
  logic          ref_half;
  logic          ref_slow;
  logic [SW-1:0] slow_cnt;
  mon_src_e      src;

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n)     pc_half <= 1'b0;
    else if (pc_tc) pc_half <= ~pc_half;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_half <= 1'b0;
      ref_slow <= 1'b0;
      slow_cnt <= '0;
    end else if (ref_tc) begin
      ref_half <= ~ref_half;
      if (slow_cnt == SW'(SLOW_HALF - 1)) begin
        slow_cnt <= '0;
        ref_slow <= ~ref_slow;
      end else begin
        slow_cnt <= slow_cnt + 1'b1;
      end
    end
  end

  assign src    = mon_src_e'(test_code[1:0]);
  assign cp_hiz = test_code[2];

  always_comb begin
    if (test_code == 3'b111) begin
      mon_out = ref_tc;
    end else begin
      case (src)
        SRC_LOCK:     mon_out = lock_in;
        SRC_REF_HALF: mon_out = ref_half;
        SRC_PC_HALF:  mon_out = pc_half;
        default:      mon_out = ref_slow;
      endcase
    end
  end

  // R9: halved reference flips only after a reference pulse
  p_ref_half_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$stable(ref_half) |-> $past(ref_tc));

  // R10: halved chain output flips only after a chain pulse
  p_pc_half_r10: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !$stable(pc_half) |-> $past(pc_tc));

  // R11: slow output flips only after a reference pulse
  p_slow_r11: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$stable(ref_slow) |-> $past(ref_tc));

endmodule

// File: rtl/pll_div_core.sv
module pll_div_core #(
  parameter int PRE_BASE = 32,
  parameter int MAIN_W   = 2,
  parameter int SWAL_W   = 5,
  parameter int REF_W    = 2,
  parameter int SLOW_DIV = 512
) (
  input  logic              vco_clk,
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic [MAIN_W-1:0] main_code,
  input  logic [SWAL_W-1:0] swallow_code,
  input  logic [REF_W-1:0]  ref_code,
  input  logic [2:0]        test_code,
  input  logic              lock_in,
  output logic              pc_pulse,
  output logic              ref_pulse,
  output logic              mon_out,
  output logic              cp_hiz
);
  logic pre_tc;
  logic mod_hi;
  logic pc_tc;
  logic ref_tc;

  dual_mod_prescaler #(.BASE(PRE_BASE)) u_pre (
    .clk(vco_clk), .rst_n(rst_n), .mod_hi(mod_hi), .tc(pre_tc)
  );

  swallow_ctrl #(.BASE(PRE_BASE), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_swal (
    .clk(vco_clk), .rst_n(rst_n), .pre_tc(pre_tc),
    .main_code(main_code), .swallow_code(swallow_code),
    .mod_hi(mod_hi), .pc_tc(pc_tc)
  );

  ref_divider #(.REF_W(REF_W)) u_ref (
    .clk(ref_clk), .rst_n(rst_n), .ref_code(ref_code), .tc(ref_tc)
  );

  mon_tap #(.SLOW_DIV(SLOW_DIV)) u_mon (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .pc_tc(pc_tc), .ref_tc(ref_tc), .lock_in(lock_in),
    .test_code(test_code), .mon_out(mon_out), .cp_hiz(cp_hiz)
  );

  assign pc_pulse  = pc_tc;
  assign ref_pulse = ref_tc;

endmodule

// File: tb/pll_div_core_test.sv
`timescale 1ns/100ps
module pll_div_core_test;
  logic       vco_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] main_code    = 2'd3;
  logic [4:0] swallow_code = 5'd9;
  logic [1:0] ref_code     = 2'd2;
  logic [2:0] test_code    = 3'b000;
  logic       lock_in      = 1'b1;
  logic       pc_pulse, ref_pulse, mon_out, cp_hiz;

  int checks = 0;
  int errors = 0;
  int ref_tab [4] = '{3, 4, 6, 8};

  pll_div_core uut (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .main_code(main_code), .swallow_code(swallow_code),
    .ref_code(ref_code), .test_code(test_code), .lock_in(lock_in),
    .pc_pulse(pc_pulse), .ref_pulse(ref_pulse),
    .mon_out(mon_out), .cp_hiz(cp_hiz)
  );

  always #1  vco_clk = ~vco_clk;
  always #10 ref_clk = ~ref_clk;

  function automatic int expect_chain(input int m, input int s);
    return 1024 + m * 32 + s;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pc(input int start, output int n);
    n = start;
    do begin @(negedge vco_clk); n++; end while (pc_pulse !== 1'b1 && n < 5000);
  endtask

  task automatic wait_ref(input int start, output int n);
    n = start;
    do begin @(negedge ref_clk); n++; end while (ref_pulse !== 1'b1 && n < 100);
  endtask

  task automatic wait_mon_vco(output int n);
    logic prev;
    prev = mon_out;
    n = 0;
    do begin @(negedge vco_clk); n++; end while (mon_out === prev && n < 5000);
  endtask

  task automatic wait_mon_ref(output int n);
    logic prev;
    prev = mon_out;
    n = 0;
    do begin @(negedge ref_clk); n++; end while (mon_out === prev && n < 4000);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, n2;
    #35;
    check(pc_pulse === 1'b0, "R7 pc_pulse in reset", int'(pc_pulse), 0);
    check(ref_pulse === 1'b0, "R7 ref_pulse in reset", int'(ref_pulse), 0);
    check(mon_out === 1'b1, "R8 lock on monitor in reset", int'(mon_out), 1);
    check(cp_hiz === 1'b0, "R12 cp_hiz in reset", int'(cp_hiz), 0);
    #5.5;
    rst_n = 1'b1;
    // the release cycle itself is cycle 1, so counts are one less than the cycle number
    fork
      begin
        wait_pc(0, n);
        check(n == 1023, "R7 first chain pulse", n, 1023);
        wait_pc(0, n);
        check(n == expect_chain(3, 9), "R6 codes taken at first pulse", n, expect_chain(3, 9));
      end
      begin
        wait_ref(0, n2);
        check(n2 == 2, "R7 first reference pulse", n2, 2);
        wait_ref(0, n2);
        check(n2 == 6, "R6 R4 reference code taken", n2, 6);
      end
    join

    // R1 R2 R3: every main and swallow code combination
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 32; s++) begin
        main_code    = 2'(m);
        swallow_code = 5'(s);
        wait_pc(0, n);
        check(n == expect_chain(m, s), "R1 R2 R3 chain period", n, expect_chain(m, s));
      end
    end

    // R5: pulse is gone in the next cycle
    @(negedge vco_clk);
    check(pc_pulse === 1'b0, "R5 pc_pulse width", int'(pc_pulse), 0);
    wait_pc(1, n);
    check(n == expect_chain(3, 31), "R5 period after width check", n, expect_chain(3, 31));

    // R6: change in mid period does not shorten it
    main_code = 2'd1; swallow_code = 5'd5;
    wait_pc(0, n);
    check(n == expect_chain(1, 5), "R6 new code period", n, expect_chain(1, 5));
    for (int i = 0; i < 300; i++) @(negedge vco_clk);
    main_code = 2'd3; swallow_code = 5'd17;
    wait_pc(300, n);
    check(n == expect_chain(1, 5), "R6 mid-period change ignored", n, expect_chain(1, 5));
    wait_pc(0, n);
    check(n == expect_chain(3, 17), "R6 change applied next period", n, expect_chain(3, 17));

    // R4 R5: reference ratios
    wait_ref(0, n);
    for (int c = 0; c < 4; c++) begin
      ref_code = 2'(c);
      wait_ref(0, n);
      check(n == ref_tab[c], "R4 reference period", n, ref_tab[c]);
    end
    @(negedge ref_clk);
    check(ref_pulse === 1'b0, "R5 ref_pulse width", int'(ref_pulse), 0);

    // R8 R12
    lock_in = 1'b0; #1;
    check(mon_out === 1'b0, "R8 code 000 low lock", int'(mon_out), 0);
    test_code = 3'b100; lock_in = 1'b1; #1;
    check(mon_out === 1'b1, "R8 code 100 lock", int'(mon_out), 1);
    for (int t = 0; t < 8; t++) begin
      test_code = 3'(t); #1;
      check(cp_hiz === t[2], "R12 cp_hiz", int'(cp_hiz), int'(t[2]));
    end

    // R9: reference halved
    wait_ref(0, n);
    ref_code = 2'd1;
    wait_ref(0, n);
    test_code = 3'b001;
    @(negedge ref_clk);
    wait_mon_ref(n);
    wait_mon_ref(n);
    check(n == 4, "R9 code 001 half period", n, 4);
    test_code = 3'b101;
    @(negedge ref_clk);
    wait_mon_ref(n);
    wait_mon_ref(n);
    check(n == 4, "R9 code 101 half period", n, 4);

    // R10: chain halved
    wait_pc(0, n);
    main_code = 2'd2; swallow_code = 5'd7;
    wait_pc(0, n);
    test_code = 3'b010;
    @(negedge vco_clk);
    wait_mon_vco(n);
    wait_mon_vco(n);
    check(n == expect_chain(2, 7), "R10 code 010 half period", n, expect_chain(2, 7));
    test_code = 3'b110;
    @(negedge vco_clk);
    wait_mon_vco(n);
    wait_mon_vco(n);
    check(n == expect_chain(2, 7), "R10 code 110 half period", n, expect_chain(2, 7));

    // R11: slow reference and raw pulse
    wait_ref(0, n);
    ref_code = 2'd0;
    wait_ref(0, n);
    test_code = 3'b011;
    @(negedge ref_clk);
    wait_mon_ref(n);
    wait_mon_ref(n);
    check(n == 256 * 3, "R11 code 011 half period", n, 768);
    test_code = 3'b111;
    begin
      int bad, highs;
      bad = 0; highs = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge ref_clk);
        if (mon_out !== ref_pulse) bad++;
        if (ref_pulse === 1'b1) highs++;
      end
      check(bad == 0 && highs == 4, "R11 code 111 raw pulse", highs - bad * 100, 4);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule